// File: doc/BRIEF.md
# Bidirectional Multiplexed Latch Bank

This block joins one 12-bit A port to two 12-bit B ports, B1 and B2, through four level-sensitive latches. Going from B to A, each B port has its own latch, and a select input picks which of the two latched words reaches A. Going from A to B, the A word feeds two separate latches, one per B port. This lets two successive A words, such as an address and a data word, be split across the two B banks.

Each port has its own active-low output enable. A disabled port stops driving, but the latches behind it keep their contents. Ports are modelled as a separate input vector, output vector and output-valid flag, so no tri-state nets are needed. A disabled port reports valid low and drives zeros on its output vector.

The latches run from a system clock. While a latch enable is high, its output follows its input within the same cycle. At each rising clock edge where the enable is high, the latch stores that input. Once the enable is low, the latch shows the word from the last edge at which its enable was high. An active-low reset clears all four latches and forces every port to the disabled state.

Top module: `mux_latch_bank`

## Requirements
- R1: While `rst_n` is low, `a_valid`, `b1_valid` and `b2_valid` are 0 and `a_out`, `b1_out`, `b2_out` are all zero.
- R2: While a latch enable is 1, the output fed by that latch equals the latch's input in the same cycle.
- R3: After a latch enable goes to 0, the output fed by that latch keeps the input value sampled at the last rising clock edge at which the enable was 1.
- R4: With `sel` = 1, `a_out` shows the B1-to-A latch (enable `le_b1a`, input `b1_in`). With `sel` = 0, it shows the B2-to-A latch (enable `le_b2a`, input `b2_in`).
- R5: The latch enable of the B-to-A path that `sel` does not pick has no effect on `a_out`.
- R6: `b1_out` shows the A-to-B1 latch (`le_ab1`) and `b2_out` shows the A-to-B2 latch (`le_ab2`). Both latches take `a_in`, and either one can be transparent while the other holds.
- R7: Output enables are active low and independent. A port whose enable is 1 has valid = 0 and output all zeros. A port whose enable is 0 (out of reset) has valid = 1.
- R8: A latch keeps its contents while its port is disabled, and it can also load while its port is disabled. When the port is enabled again, the port shows the stored word.
- R9: Reset has priority over every latch enable. Latches whose enable was 1 during reset still hold zero after reset is released.
- R10: In a bus-interleave sequence, two A words are captured into B1 and then B2 and looped back into the B ports. Toggling `sel` then returns each word on A unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; latches store on rising edges |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | B-to-A source select: 1 = B1 latch, 0 = B2 latch |
| le_b1a | input | 1 | B1-to-A latch enable |
| le_b2a | input | 1 | B2-to-A latch enable |
| le_ab1 | input | 1 | A-to-B1 latch enable |
| le_ab2 | input | 1 | A-to-B2 latch enable |
| a_oe_n | input | 1 | A port output enable, active low |
| b1_oe_n | input | 1 | B1 port output enable, active low |
| b2_oe_n | input | 1 | B2 port output enable, active low |
| a_in | input | 12 | Word arriving on the A port |
| b1_in | input | 12 | Word arriving on the B1 port |
| b2_in | input | 12 | Word arriving on the B2 port |
| a_out | output | 12 | Word driven onto A (zero when disabled) |
| a_valid | output | 1 | A port is driving |
| b1_out | output | 12 | Word driven onto B1 (zero when disabled) |
| b1_valid | output | 1 | B1 port is driving |
| b2_out | output | 12 | Word driven onto B2 (zero when disabled) |
| b2_valid | output | 1 | B2 port is driving |

## Verification
Two functions can fall in the same cycle: a latch becoming transparent, and a change of the select or output enable that decides whether that latch is seen. The bench provokes this by raising the unselected B-to-A enable while new data sits on its input and `sel` stays put. It also provokes it by loading an A-to-B latch while its port is disabled and enabling the port on the cycle the enable drops. A behavioural model, holding four stored words, predicts every output on every clock. The outcome is judged by whether `a_out` stays put in the first case and whether the stored word appears once the port drives in the second.

// File: rtl/mlb_pkg.sv
package mlb_pkg;
   localparam int unsigned NBANK = 2;

   typedef enum logic {
      PICK_B2 = 1'b0,
      PICK_B1 = 1'b1
   } pick_e;
endpackage

// File: rtl/mlb_latch_cell.sv
module mlb_latch_cell #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         le,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  held <= '0;
      else if (le) held <= d;
   end

   // reset overrides the transparent path as well
   always_comb begin
      if (!rst_n)  q = '0;
      else if (le) q = d;
      else         q = held;
   end
endmodule

// File: rtl/mlb_port_gate.sv
module mlb_port_gate #(
   parameter int unsigned W = 12
) (
   input  logic         rst_n,
   input  logic         oe_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         valid
);
   logic drive;

   assign drive = rst_n & ~oe_n;
   assign valid = drive;
   assign q     = drive ? d : '0;
endmodule

// File: rtl/mlb_a_select.sv
module mlb_a_select
   import mlb_pkg::*;
#(
   parameter int unsigned W = 12
) (
   input  pick_e                   pick,
   input  logic [NBANK-1:0][W-1:0] src,
   output logic [W-1:0]            q
);
   always_comb begin
      unique case (pick)
         PICK_B1: q = src[0];
         PICK_B2: q = src[1];
         default: q = '0;
      endcase
   end
endmodule

// File: rtl/mux_latch_bank.sv
module mux_latch_bank
   import mlb_pkg::*;
#(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sel,
   input  logic         le_b1a,
   input  logic         le_b2a,
   input  logic         le_ab1,
   input  logic         le_ab2,
   input  logic         a_oe_n,
   input  logic         b1_oe_n,
   input  logic         b2_oe_n,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b1_in,
   input  logic [W-1:0] b2_in,
   output logic [W-1:0] a_out,
   output logic         a_valid,
   output logic [W-1:0] b1_out,
   output logic         b1_valid,
   output logic [W-1:0] b2_out,
   output logic         b2_valid
);
   generate
      if (W < 1 || W > 1024) begin : g_bad_width
         $error("mux_latch_bank: W must lie in 1..1024");
      end
   endgenerate

   logic [NBANK-1:0]        le_up, le_dn, b_oe_n, b_valid;
   logic [NBANK-1:0][W-1:0] b_in, up_q, dn_q, b_q;
   logic [W-1:0]            a_pick;

   assign le_up  = {le_b2a, le_b1a};
   assign le_dn  = {le_ab2, le_ab1};
   assign b_oe_n = {b2_oe_n, b1_oe_n};
   assign b_in   = {b2_in, b1_in};

   // one B-to-A latch, one A-to-B latch and one port gate per B bank
   for (genvar i = 0; i < NBANK; i++) begin : g_bank
      mlb_latch_cell #(.W(W)) u_up (
         .clk(clk), .rst_n(rst_n), .le(le_up[i]), .d(b_in[i]), .q(up_q[i])
      );
      mlb_latch_cell #(.W(W)) u_dn (
         .clk(clk), .rst_n(rst_n), .le(le_dn[i]), .d(a_in), .q(dn_q[i])
      );
      mlb_port_gate #(.W(W)) u_gate (
         .rst_n(rst_n), .oe_n(b_oe_n[i]), .d(dn_q[i]), .q(b_q[i]),
         .valid(b_valid[i])
      );
   end

   mlb_a_select #(.W(W)) u_sel (
      .pick(pick_e'(sel)), .src(up_q), .q(a_pick)
   );

   mlb_port_gate #(.W(W)) u_a_gate (
      .rst_n(rst_n), .oe_n(a_oe_n), .d(a_pick), .q(a_out), .valid(a_valid)
   );

   assign b1_out   = b_q[0];
   assign b2_out   = b_q[1];
   assign b1_valid = b_valid[0];
   assign b2_valid = b_valid[1];
endmodule

// File: rtl/mlb_checker.sv
module mlb_checker #(
   parameter int unsigned W = 12
) (
   input logic         clk,
   input logic         rst_n,
   input logic         sel,
   input logic         le_b1a,
   input logic         le_b2a,
   input logic         le_ab1,
   input logic         le_ab2,
   input logic         a_oe_n,
   input logic         b1_oe_n,
   input logic         b2_oe_n,
   input logic [W-1:0] a_in,
   input logic [W-1:0] b1_in,
   input logic [W-1:0] b2_in,
   input logic [W-1:0] a_out,
   input logic         a_valid,
   input logic [W-1:0] b1_out,
   input logic         b1_valid,
   input logic [W-1:0] b2_out,
   input logic         b2_valid
);
   // R1: reset silences every port
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!a_valid && !b1_valid && !b2_valid && a_out == '0 &&
                  b1_out == '0 && b2_out == '0));

   // R2 / R4: transparent selected B latch reaches A
   a_r4_pick_b1: assert property (@(posedge clk) disable iff (!rst_n)
      (a_valid && sel && le_b1a) |-> a_out == b1_in);
   a_r4_pick_b2: assert property (@(posedge clk) disable iff (!rst_n)
      (a_valid && !sel && le_b2a) |-> a_out == b2_in);

   // R6: transparent A-to-B latches reach their ports
   a_r6_b1_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (b1_valid && le_ab1) |-> b1_out == a_in);
   a_r6_b2_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (b2_valid && le_ab2) |-> b2_out == a_in);

   // R3: a closed latch holds its word
   a_r3_b1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!le_ab1 && $past(!le_ab1) && b1_valid && $past(b1_valid))
      |-> $stable(b1_out));

   // R5: unselected enable cannot disturb A
   a_r5_unpicked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && $past(!sel) && !le_b2a && $past(!le_b2a) &&
       a_valid && $past(a_valid)) |-> $stable(a_out));

   // R7: disabled port drives zeros
   a_r7_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_valid |-> a_out == '0) and (!b1_valid |-> b1_out == '0) and
      (!b2_valid |-> b2_out == '0));
endmodule

bind mux_latch_bank mlb_checker #(.W(W)) u_chk (.*);

// File: tb/mux_latch_bank_test.sv
`timescale 1ns/1ps
module mux_latch_bank_test;
   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sel = 1'b0, le_b1a = 1'b0, le_b2a = 1'b0, le_ab1 = 1'b0, le_ab2 = 1'b0;
   logic         a_oe_n = 1'b0, b1_oe_n = 1'b0, b2_oe_n = 1'b0;
   logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
   logic [W-1:0] a_out, b1_out, b2_out;
   logic         a_valid, b1_valid, b2_valid;

   int    n_chk = 0, n_bad = 0;
   string tag = "R1";
   bit    done = 1'b0;

   // behavioural reference: four stored words
   logic [W-1:0] m_up1 = '0, m_up2 = '0, m_dn1 = '0, m_dn2 = '0;

   always #5 clk = ~clk;

   mux_latch_bank #(.W(W)) uut (.*);

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_up1 <= '0; m_up2 <= '0; m_dn1 <= '0; m_dn2 <= '0;
      end else begin
         if (le_b1a) m_up1 <= b1_in;
         if (le_b2a) m_up2 <= b2_in;
         if (le_ab1) m_dn1 <= a_in;
         if (le_ab2) m_dn2 <= a_in;
      end
   end

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      logic [W-1:0] ea, e1, e2;
      logic         va, v1, v2;
      va = rst_n && !a_oe_n;
      v1 = rst_n && !b1_oe_n;
      v2 = rst_n && !b2_oe_n;
      ea = sel ? (le_b1a ? b1_in : m_up1) : (le_b2a ? b2_in : m_up2);
      e1 = le_ab1 ? a_in : m_dn1;
      e2 = le_ab2 ? a_in : m_dn2;
      if (!done) begin
         chk({tag, " a_out"},  a_out,  va ? ea : '0);
         chk({tag, " b1_out"}, b1_out, v1 ? e1 : '0);
         chk({tag, " b2_out"}, b2_out, v2 ? e2 : '0);
         chk({tag, " valids"}, {9'd0, a_valid, b1_valid, b2_valid}, {9'd0, va, v1, v2});
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic look();
      @(negedge clk);
      #1;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [W-1:0] w1, w2;
      // R1 / R9: reset with every enable open
      tag = "R1";
      le_b1a = 1; le_b2a = 1; le_ab1 = 1; le_ab2 = 1;
      a_in = 12'hABC; b1_in = 12'h321; b2_in = 12'h654;
      repeat (3) tick();
      look();
      chk("R1 a_out in reset", a_out, '0);
      chk("R1 valid in reset", {9'd0, a_valid, b1_valid, b2_valid}, '0);
      tick();
      tag = "R9";
      le_b1a = 0; le_b2a = 0; le_ab1 = 0; le_ab2 = 0; rst_n = 1;
      look();
      chk("R9 b1 after reset", b1_out, '0);
      chk("R9 a after reset", a_out, '0);

      // R2 / R3: transparent then hold
      tick(); tag = "R2";
      a_in = 12'h123; le_ab1 = 1;
      look(); chk("R2 b1 transparent", b1_out, 12'h123);
      tick(); tag = "R3";
      le_ab1 = 0; a_in = 12'h456;
      look(); chk("R3 b1 holds", b1_out, 12'h123);
      chk("R6 b2 untouched", b2_out, '0);

      // R6: B2 loads while B1 holds
      tick(); tag = "R6";
      le_ab2 = 1;
      look(); chk("R6 b2 transparent", b2_out, 12'h456);
      chk("R6 b1 still holds", b1_out, 12'h123);
      tick(); le_ab2 = 0; a_in = 12'h789;
      look(); chk("R6 b2 holds", b2_out, 12'h456);

      // R4: select between B latches
      tick(); tag = "R4";
      b1_in = 12'h111; b2_in = 12'h222; le_b1a = 1; le_b2a = 1; sel = 1;
      look(); chk("R4 sel=1 picks B1", a_out, 12'h111);
      tick(); sel = 0;
      look(); chk("R4 sel=0 picks B2", a_out, 12'h222);
      tick(); le_b1a = 0; le_b2a = 0; b1_in = 12'h333; b2_in = 12'h444; sel = 1;
      look(); chk("R4 held B1", a_out, 12'h111);
      tick(); sel = 0;
      look(); chk("R4 held B2", a_out, 12'h222);

      // R5: unselected enable changes nothing on A
      tick(); tag = "R5";
      b1_in = 12'h555; le_b1a = 1;
      look(); chk("R5 a ignores le_b1a", a_out, 12'h222);
      tick(); le_b1a = 0; sel = 1;
      look(); chk("R5 b1 latch took 555", a_out, 12'h555);

      // R7: independent active-low enables
      tick(); tag = "R7";
      a_oe_n = 1; b1_oe_n = 1; b2_oe_n = 0;
      look();
      chk("R7 a off", {11'd0, a_valid}, '0);
      chk("R7 a zero", a_out, '0);
      chk("R7 b1 off zero", b1_out, '0);
      chk("R7 b2 on", b2_out, 12'h456);

      // R8: load while disabled, show when re-enabled
      tick(); tag = "R8";
      a_in = 12'h9AB; le_ab1 = 1;
      tick(); le_ab1 = 0; b1_oe_n = 0; a_oe_n = 0; a_in = 12'h000;
      look();
      chk("R8 b1 stored word", b1_out, 12'h9AB);
      chk("R8 a stored word", a_out, 12'h555);

      // R10: bus interleave with loopback
      tick(); tag = "R10";
      w1 = 12'hC3A; w2 = 12'h5E1;
      a_in = w1; le_ab1 = 1;
      tick(); le_ab1 = 0; a_in = w2; le_ab2 = 1;
      tick(); le_ab2 = 0; a_in = 12'h000;
      b1_in = b1_out; b2_in = b2_out; le_b1a = 1; le_b2a = 1;
      tick(); le_b1a = 0; le_b2a = 0; b1_in = 12'hFFF; b2_in = 12'h0F0; sel = 1;
      look(); chk("R10 first word back", a_out, w1);
      tick(); sel = 0;
      look(); chk("R10 second word back", a_out, w2);

      // mixed traffic checked against the model every clock
      tag = "R6";
      for (int k = 0; k < 400; k++) begin
         tick();
         {sel, le_b1a, le_b2a, le_ab1, le_ab2} = 5'($urandom);
         {a_oe_n, b1_oe_n, b2_oe_n} = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
         a_in = 12'($urandom); b1_in = 12'($urandom); b2_in = 12'($urandom);
         if (k == 200) rst_n = 0;
         if (k == 203) rst_n = 1;
      end
      tick();
      look();
      finish_run();
   end
endmodule